// File: doc/BRIEF.md
# Latched Status and Interrupt Register Bank

This block keeps the three host-visible registers of a parallel storage-bus controller that report what has happened on the bus: a status byte, an interrupt cause byte and a sequence-step value. The controller's sequencers send it single-cycle event pulses: bus errors, terminal count, valid group code, and the eight interrupt causes. The block latches these events until the host reads the interrupt cause register. It also passes the three live bus phase lines straight through into the low bits of the status byte.

The host reads with a strobe and a two-bit register select. The read data is combinational from the current register contents, so a clearing read returns the values held before the clear. An interrupt request goes out whenever an interrupt cause is latched and the enable input is high. A configuration input can silence a bus-reset cause when the controller's own reset-bus command caused that reset.

Top module: `sir_status_intr`

## Requirements
- R1: Status byte (select 0) bits 0, 1 and 2 show `phase_i[0]` (I/O), `phase_i[1]` (C/D) and `phase_i[2]` (MSG) live, with no latching. Phases are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in. A status read does not change any latched state.
- R2: Status bits 6, 5, 4 and 3 latch `gross_err_i`, `parity_err_i`, `term_count_i` and `group_ok_i` respectively, and hold until the interrupt cause register is read.
- R3: The interrupt cause byte (select 1) latches `cause_i`, bit for bit. The bits are 7 bus reset seen, 6 illegal command, 5 disconnect or timeout, 4 service request, 3 function complete, 2 reselected, 1 selected with attention, 0 selected without attention.
- R4: Status bit 7 (pending) is 1 exactly when at least one interrupt cause is latched, whatever the value of `irq_en_i`.
- R5: `irq_o` is the pending bit ANDed with `irq_en_i`.
- R6: A read with select 1 while `rd_i` is high returns the pre-clear cause byte. At the next clock it clears the causes, status bits 7..3 and the step value.
- R7: An event (or step load) arriving in the same cycle as a clearing read stays latched after that read.
- R8: `rst_ni` low (asynchronous) or `soft_rst_i` high at a clock edge clears all latched state. Events in a soft-reset cycle are dropped.
- R9: When `cmd_rst_quiet_i` and `bus_rst_from_cmd_i` are both high, cause bit 7 is not latched and does not set pending. Bus resets not flagged as command-caused are latched as usual.
- R10: Select 2 returns the 3-bit step value in bits 2..0, with zeros above it. `step_load_i` loads `step_val_i`, and otherwise the value holds. The value 4 means the whole sequence completed.
- R11: Select 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 3 | Live bus phase lines {MSG, C/D, I/O} |
| gross_err_i | input | 1 | Gross error event pulse |
| parity_err_i | input | 1 | Parity error event pulse |
| term_count_i | input | 1 | Terminal count event pulse |
| group_ok_i | input | 1 | Valid group code event pulse |
| cause_i | input | 8 | Interrupt cause event pulses |
| bus_rst_from_cmd_i | input | 1 | Bus reset this cycle came from the reset-bus command |
| cmd_rst_quiet_i | input | 1 | Configuration: silence command-caused bus reset |
| step_load_i | input | 1 | Load the sequence-step value |
| step_val_i | input | 3 | New sequence-step value |
| soft_rst_i | input | 1 | Software reset of latched state |
| rd_i | input | 1 | Host read strobe |
| rd_sel_i | input | 2 | Register select: 0 status, 1 cause, 2 step, 3 reserved |
| irq_en_i | input | 1 | Interrupt output enable |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the clearing read that meets a new event in the same cycle. A design that let the clear win would lose that event, and the next cause read would come back empty. It checks that the pending bit still rises while the output enable is low: a design that tied pending to the enable would show status bit 7 as 0. It drives a command-caused bus reset with and without the silencing input. This exposes a design that drops every bus reset, and one that ignores the configuration bit. It also checks that status reads leave the latched bits alone and that the phase bits follow the lines after a clear. A design that latched the phase, or cleared on a status read, would then return stale or missing bits.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_STEP   = 2'd2,
    SEL_RSVD   = 2'd3
  } rd_sel_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CAUSE_W   = 8;
  localparam int unsigned STAT_EV_W = 4;
  localparam int unsigned PHASE_W   = 3;
  localparam int unsigned STEP_W    = 3;
  localparam int unsigned BUS_RST_BIT = 7;
  localparam logic [STEP_W-1:0] STEP_DONE = 3'd4;
endpackage

// File: rtl/sir_sticky.sv
module sir_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[i] <= 1'b0;
      else if (clr_i) q_o[i] <= set_i[i];   // same-cycle event survives clear
      else            q_o[i] <= q_o[i] | set_i[i];
    end

    a_r7_keep_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && set_i[i]) |=> q_o[i]);
    a_r2_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && q_o[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/sir_step_reg.sv
module sir_step_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= val_i;
    else if (clr_i)  q_o <= '0;
  end

  a_r10_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(q_o));
  a_r6_step_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> (q_o == '0));
endmodule

// File: rtl/sir_read_mux.sv
module sir_read_mux
  import sir_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned SW = STEP_W
) (
  input  rd_sel_e         sel_i,
  input  logic [DW-1:0]   status_i,
  input  logic [DW-1:0]   cause_i,
  input  logic [SW-1:0]   step_i,
  output logic [DW-1:0]   data_o
);
  localparam int unsigned PAD_W = DW - SW;

  always_comb begin
    unique case (sel_i)
      SEL_STATUS: data_o = status_i;
      SEL_CAUSE:  data_o = cause_i;
      SEL_STEP:   data_o = {{PAD_W{1'b0}}, step_i};
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/sir_status_intr.sv
module sir_status_intr
  import sir_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PHASE_W-1:0]   phase_i,
  input  logic                 gross_err_i,
  input  logic                 parity_err_i,
  input  logic                 term_count_i,
  input  logic                 group_ok_i,
  input  logic [CAUSE_W-1:0]   cause_i,
  input  logic                 bus_rst_from_cmd_i,
  input  logic                 cmd_rst_quiet_i,
  input  logic                 step_load_i,
  input  logic [STEP_W-1:0]    step_val_i,
  input  logic                 soft_rst_i,
  input  logic                 rd_i,
  input  logic [1:0]           rd_sel_i,
  input  logic                 irq_en_i,
  output logic [BYTE_W-1:0]    rd_data_o,
  output logic                 irq_o
);
  rd_sel_e                sel;
  logic                   clr;
  logic [CAUSE_W-1:0]     cause_mask;
  logic [CAUSE_W-1:0]     cause_acc;
  logic [STAT_EV_W-1:0]   stat_set;
  logic [CAUSE_W-1:0]     cause_q;
  logic [STAT_EV_W-1:0]   stat_q;
  logic [0:0]             pend_q;
  logic [STEP_W-1:0]      step_q;
  logic [BYTE_W-1:0]      status_byte;

  assign sel = rd_sel_e'(rd_sel_i);
  assign clr = soft_rst_i | (rd_i & (sel == SEL_CAUSE));

  always_comb begin
    cause_mask = '1;
    cause_mask[BUS_RST_BIT] = ~(bus_rst_from_cmd_i & cmd_rst_quiet_i);
  end

  assign cause_acc = soft_rst_i ? '0 : (cause_i & cause_mask);
  assign stat_set  = soft_rst_i ? '0 :
                     {gross_err_i, parity_err_i, term_count_i, group_ok_i};

  sir_sticky #(.W(CAUSE_W)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .set_i(cause_acc), .q_o(cause_q));

  sir_sticky #(.W(STAT_EV_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .set_i(stat_set), .q_o(stat_q));

  sir_sticky #(.W(1)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .set_i(|cause_acc), .q_o(pend_q));

  sir_step_reg #(.W(STEP_W)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .load_i(step_load_i & ~soft_rst_i), .val_i(step_val_i), .q_o(step_q));

  assign status_byte = {pend_q, stat_q, phase_i};

  sir_read_mux #(.DW(BYTE_W), .SW(STEP_W)) u_mux (
    .sel_i(sel), .status_i(status_byte), .cause_i(cause_q),
    .step_i(step_q), .data_o(rd_data_o));

  assign irq_o = pend_q[0] & irq_en_i;

  a_r4_pend_matches_causes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[0] == (cause_q != '0));
  a_r9_quiet_cmd_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rst_quiet_i && bus_rst_from_cmd_i && !cause_q[BUS_RST_BIT]) |=> !cause_q[BUS_RST_BIT]);
  a_r8_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (cause_q == '0 && stat_q == '0 && !pend_q[0] && step_q == '0));
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == SEL_CAUSE && cause_i == '0) |=> (cause_q == '0 && !irq_o));
endmodule

// File: tb/sir_status_intr_test.sv
module sir_status_intr_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] phase_i = '0;
  logic gross_err_i = 0, parity_err_i = 0, term_count_i = 0, group_ok_i = 0;
  logic [7:0] cause_i = '0;
  logic bus_rst_from_cmd_i = 0, cmd_rst_quiet_i = 0;
  logic step_load_i = 0;
  logic [2:0] step_val_i = '0;
  logic soft_rst_i = 0, rd_i = 0;
  logic [1:0] rd_sel_i = '0;
  logic irq_en_i = 0;
  logic [7:0] rd_data_o;
  logic irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sir_status_intr uut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_i(phase_i),
    .gross_err_i(gross_err_i), .parity_err_i(parity_err_i),
    .term_count_i(term_count_i), .group_ok_i(group_ok_i),
    .cause_i(cause_i), .bus_rst_from_cmd_i(bus_rst_from_cmd_i),
    .cmd_rst_quiet_i(cmd_rst_quiet_i), .step_load_i(step_load_i),
    .step_val_i(step_val_i), .soft_rst_i(soft_rst_i), .rd_i(rd_i),
    .rd_sel_i(rd_sel_i), .irq_en_i(irq_en_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o));

  typedef struct packed {
    logic [2:0] ph;
    logic [3:0] st;   // {gross, parity, term, group}
    logic [7:0] ev;
    logic       en;
    logic [7:0] xs;
    logic [7:0] xi;
    logic       xirq;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{3'd0, 4'b0000, 8'h08, 1'b1, 8'h80, 8'h08, 1'b1},
    '{3'd1, 4'b1000, 8'h00, 1'b1, 8'h41, 8'h00, 1'b0},
    '{3'd2, 4'b0100, 8'h10, 1'b0, 8'hA2, 8'h10, 1'b0},
    '{3'd3, 4'b0010, 8'h80, 1'b1, 8'h93, 8'h80, 1'b1},
    '{3'd6, 4'b0001, 8'h20, 1'b1, 8'h8E, 8'h20, 1'b1},
    '{3'd7, 4'b1111, 8'hFF, 1'b1, 8'hFF, 8'hFF, 1'b1},
    '{3'd1, 4'b0000, 8'h05, 1'b0, 8'h81, 8'h05, 1'b0},
    '{3'd2, 4'b0000, 8'h00, 1'b1, 8'h02, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] d);
    rd_i = 0;
    rd_sel_i = sel;
    #1;
    d = rd_data_o;
  endtask

  // clearing read: returns pre-clear byte, clear lands at next edge
  task automatic read_cause(output logic [7:0] d);
    rd_i = 1;
    rd_sel_i = 2'd1;
    #1;
    d = rd_data_o;
    tick();
    rd_i = 0;
  endtask

  task automatic pulse(input logic [3:0] st, input logic [7:0] ev);
    {gross_err_i, parity_err_i, term_count_i, group_ok_i} = st;
    cause_i = ev;
    tick();
    {gross_err_i, parity_err_i, term_count_i, group_ok_i} = '0;
    cause_i = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    #(CLK_P * 2 + 2);
    // reset state
    peek(2'd0, d); chk("R8 reset status", d, 8'h00);
    peek(2'd1, d); chk("R8 reset cause", d, 8'h00);
    peek(2'd2, d); chk("R8 reset step", d, 8'h00);
    chk("R5 reset irq", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    rst_ni = 1;
    tick();

    // table walk: R1 R2 R3 R4 R5 R6
    foreach (TBL[i]) begin
      phase_i = TBL[i].ph;
      irq_en_i = TBL[i].en;
      pulse(TBL[i].st, TBL[i].ev);
      peek(2'd0, d); chk($sformatf("R2 R4 vec%0d status", i), d, TBL[i].xs);
      chk($sformatf("R5 vec%0d irq", i), {7'b0, irq_o}, {7'b0, TBL[i].xirq});
      peek(2'd0, d); chk($sformatf("R1 vec%0d status reread", i), d, TBL[i].xs);
      read_cause(d); chk($sformatf("R3 R6 vec%0d cause", i), d, TBL[i].xi);
      peek(2'd0, d); chk($sformatf("R6 vec%0d status cleared", i), d, {5'b0, TBL[i].ph});
      peek(2'd1, d); chk($sformatf("R6 vec%0d cause cleared", i), d, 8'h00);
      chk($sformatf("R6 vec%0d irq cleared", i), {7'b0, irq_o}, 8'h00);
    end

    // R1 live phase: lines change, no edge needed
    phase_i = 3'd7; peek(2'd0, d); chk("R1 live phase 7", d, 8'h07);
    phase_i = 3'd3; peek(2'd0, d); chk("R1 live phase 3", d, 8'h03);

    // R7 collision: event in same cycle as clearing read
    irq_en_i = 1;
    pulse(4'b0000, 8'h08);
    cause_i = 8'h02; term_count_i = 1;
    step_load_i = 1; step_val_i = 3'd4;
    read_cause(d); chk("R7 read returns old", d, 8'h08);
    cause_i = '0; term_count_i = 0; step_load_i = 0;
    peek(2'd1, d); chk("R7 new cause kept", d, 8'h02);
    peek(2'd0, d); chk("R7 status kept", d, 8'h93);
    peek(2'd2, d); chk("R7 step kept", d, 8'h04);
    chk("R7 irq kept", {7'b0, irq_o}, 8'h01);
    read_cause(d);

    // R4 pending without enable
    irq_en_i = 0;
    pulse(4'b0000, 8'h40);
    peek(2'd0, d); chk("R4 pending with enable low", d, 8'h83);
    chk("R5 irq masked", {7'b0, irq_o}, 8'h00);
    irq_en_i = 1; #1;
    chk("R5 irq follows enable", {7'b0, irq_o}, 8'h01);
    read_cause(d);

    // R9 suppression
    cmd_rst_quiet_i = 1; bus_rst_from_cmd_i = 1;
    pulse(4'b0000, 8'h80);
    peek(2'd1, d); chk("R9 quiet cmd reset cause", d, 8'h00);
    peek(2'd0, d); chk("R9 quiet cmd reset pending", d, 8'h03);
    bus_rst_from_cmd_i = 0;
    pulse(4'b0000, 8'h80);
    peek(2'd1, d); chk("R9 external reset latched", d, 8'h80);
    read_cause(d);
    cmd_rst_quiet_i = 0; bus_rst_from_cmd_i = 1;
    pulse(4'b0000, 8'h80);
    peek(2'd1, d); chk("R9 not quiet latched", d, 8'h80);
    bus_rst_from_cmd_i = 0;
    read_cause(d);

    // R10 step register
    step_load_i = 1; step_val_i = 3'd4; tick(); step_load_i = 0;
    peek(2'd2, d); chk("R10 step done value", d, 8'h04);
    tick(); tick();
    peek(2'd2, d); chk("R10 step holds", d, 8'h04);
    step_load_i = 1; step_val_i = 3'd2; tick(); step_load_i = 0;
    peek(2'd2, d); chk("R10 step reload", d, 8'h02);
    read_cause(d);
    peek(2'd2, d); chk("R6 step cleared", d, 8'h00);

    // R11 reserved select
    pulse(4'b1111, 8'hFF);
    peek(2'd3, d); chk("R11 reserved zero", d, 8'h00);

    // R8 soft reset, with an event that must be dropped
    soft_rst_i = 1; cause_i = 8'h01; tick(); soft_rst_i = 0; cause_i = '0;
    peek(2'd1, d); chk("R8 soft clears cause", d, 8'h00);
    peek(2'd0, d); chk("R8 soft clears status", d, 8'h03);

    // R8 hardware reset mid-run
    pulse(4'b1000, 8'h10);
    step_load_i = 1; step_val_i = 3'd5; tick(); step_load_i = 0;
    @(negedge clk); rst_ni = 0; #1;
    peek(2'd0, d); chk("R8 hw reset status", d, 8'h03);
    peek(2'd1, d); chk("R8 hw reset cause", d, 8'h00);
    peek(2'd2, d); chk("R8 hw reset step", d, 8'h00);
    chk("R8 hw reset irq", {7'b0, irq_o}, 8'h00);
    @(negedge clk); rst_ni = 1;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule